// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Stall Unit

This block resolves data hazards in a five-stage in-order pipeline. It looks at the two source register indices of the instruction about to execute. It compares them with the destination indices of the two older instructions that are still in flight, one in the memory stage and one in the writeback stage. From that comparison it drives the select for each ALU operand multiplexer. Each operand can take the register file value, the memory-stage ALU result or the writeback value. The more recent producer wins when both older instructions match.

The block also detects the one hazard that forwarding cannot cover: a load in execute whose loaded register is a source of the instruction being decoded. In that case it raises a stall, which holds the program counter and the fetch/decode register for one cycle, and a bubble, which turns the next execute slot into a no-op. On the following cycle the dependent instruction takes the loaded value from the writeback stage through the normal forward path. The register file is assumed to return a value written in the same cycle, so the block needs no third forwarding source.

The unit is purely combinational and sits beside the pipeline registers.

Top module: `hazard_unit`

## Requirements
- R1: With no qualifying match, both operand selects are 2'b00 (register file).
- R2: When the memory-stage instruction writes a nonzero destination equal to the execute-stage first source, the first operand select is 2'b10.
- R3: When the memory-stage instruction writes a nonzero destination equal to the execute-stage second source, the second operand select is 2'b10.
- R4: When only the writeback-stage instruction writes a nonzero destination equal to a source, that operand select is 2'b01.
- R5: When both the memory-stage and the writeback-stage instructions match the same source, the select is 2'b10, because the memory-stage producer is the more recent one.
- R6: A producer whose write-enable is low never causes forwarding from its stage.
- R7: A producer whose destination is register 0 never causes forwarding, even with its write-enable high.
- R8: Stall is high exactly when the execute-stage memory-read flag is set and the execute-stage second source index (the load's destination) equals the decode-stage first or second source index.
- R9: The bubble request is high in exactly the cycles in which stall is high, and the value 2'b11 never appears on either select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idExRs | input | 5 | First source index of the instruction in execute |
| idExRt | input | 5 | Second source index of the instruction in execute (destination of a load) |
| idExMemRead | input | 1 | Instruction in execute reads data memory |
| exMemRd | input | 5 | Destination index of the instruction in memory stage |
| exMemRegWrite | input | 1 | Instruction in memory stage writes a register |
| memWbRd | input | 5 | Destination index of the instruction in writeback |
| memWbRegWrite | input | 1 | Instruction in writeback writes a register |
| ifIdRs | input | 5 | First source index of the instruction in decode |
| ifIdRt | input | 5 | Second source index of the instruction in decode |
| fwdA | output | 2 | First ALU operand select: 00 register file, 10 memory stage, 01 writeback |
| fwdB | output | 2 | Second ALU operand select, same encoding |
| stall | output | 1 | Hold PC and fetch/decode register for one cycle |
| bubble | output | 1 | Replace the next execute slot with a no-op |

## Verification
Every result of this block is due in the same cycle as the indices that cause it, because no register lies between inputs and outputs. The bench therefore changes inputs just after a rising edge and compares all four outputs at the following falling edge, half a period later, against bench functions that recompute selects and stall from R1 to R9. Random index values are drawn from a small range so that equal indices, register 0 and double matches occur often, and directed cases pin down priority and the load-use match on each decode source.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

  typedef enum logic [1:0] {
    FWD_REG = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwdSel_t;

  localparam int NUM_SRC = 2;

  typedef struct packed {
    logic [NUM_SRC-1:0] memHit;
    logic [NUM_SRC-1:0] wbHit;
    logic               loadUse;
  } hitStrobes_t;

endpackage

// File: rtl/hazard_match.sv
module hazard_match
  import hazard_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic [IDX_W-1:0] idExRs,
  input  logic [IDX_W-1:0] idExRt,
  input  logic             idExMemRead,
  input  logic [IDX_W-1:0] exMemRd,
  input  logic             exMemRegWrite,
  input  logic [IDX_W-1:0] memWbRd,
  input  logic             memWbRegWrite,
  input  logic [IDX_W-1:0] ifIdRs,
  input  logic [IDX_W-1:0] ifIdRt,
  output hitStrobes_t      strobes
);

  logic [IDX_W-1:0]   srcIdx [NUM_SRC];
  logic [NUM_SRC-1:0] memHitV;
  logic [NUM_SRC-1:0] wbHitV;
  logic               memLive;
  logic               wbLive;
  logic               loadHit;

  assign srcIdx[0] = idExRs;
  assign srcIdx[1] = idExRt;

  assign memLive = exMemRegWrite && (exMemRd != '0);
  assign wbLive  = memWbRegWrite && (memWbRd != '0);

  generate
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      assign memHitV[s] = memLive && (srcIdx[s] == exMemRd);
      assign wbHitV[s]  = wbLive  && (srcIdx[s] == memWbRd);
    end
  endgenerate

  assign loadHit = idExMemRead && ((idExRt == ifIdRs) || (idExRt == ifIdRt));

  assign strobes = '{memHit: memHitV, wbHit: wbHitV, loadUse: loadHit};

endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hazard_pkg::*;
(
  input  hitStrobes_t            strobes,
  output logic [2*NUM_SRC-1:0]   fwdBus,
  output logic                   stall,
  output logic                   bubble
);

  generate
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_sel
      fwdSel_t sel;
      always_comb begin
        if (strobes.memHit[s])     sel = FWD_MEM;
        else if (strobes.wbHit[s]) sel = FWD_WB;
        else                       sel = FWD_REG;
      end
      assign fwdBus[2*s +: 2] = sel;
    end
  endgenerate

  assign stall  = strobes.loadUse;
  assign bubble = strobes.loadUse;

endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
  import hazard_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic [IDX_W-1:0] idExRs,
  input  logic [IDX_W-1:0] idExRt,
  input  logic             idExMemRead,
  input  logic [IDX_W-1:0] exMemRd,
  input  logic             exMemRegWrite,
  input  logic [IDX_W-1:0] memWbRd,
  input  logic             memWbRegWrite,
  input  logic [IDX_W-1:0] ifIdRs,
  input  logic [IDX_W-1:0] ifIdRt,
  output logic [1:0]       fwdA,
  output logic [1:0]       fwdB,
  output logic             stall,
  output logic             bubble
);

  hitStrobes_t            strobes;
  logic [2*NUM_SRC-1:0]   fwdBus;

  hazard_match #(.IDX_W(IDX_W)) u_match (
    .idExRs(idExRs), .idExRt(idExRt), .idExMemRead(idExMemRead),
    .exMemRd(exMemRd), .exMemRegWrite(exMemRegWrite),
    .memWbRd(memWbRd), .memWbRegWrite(memWbRegWrite),
    .ifIdRs(ifIdRs), .ifIdRt(ifIdRt), .strobes(strobes)
  );

  hazard_ctrl u_ctrl (
    .strobes(strobes), .fwdBus(fwdBus), .stall(stall), .bubble(bubble)
  );

  assign fwdA = fwdBus[1:0];
  assign fwdB = fwdBus[3:2];

endmodule

// File: rtl/hazard_unit_chk.sv
module hazard_unit_chk #(
  parameter int IDX_W = 5
) (
  input logic [IDX_W-1:0] idExRs,
  input logic [IDX_W-1:0] idExRt,
  input logic             idExMemRead,
  input logic [IDX_W-1:0] exMemRd,
  input logic             exMemRegWrite,
  input logic [IDX_W-1:0] memWbRd,
  input logic             memWbRegWrite,
  input logic [1:0]       fwdA,
  input logic [1:0]       fwdB,
  input logic             stall,
  input logic             bubble
);

  always_comb begin
    // R2 R5
    if (exMemRegWrite && exMemRd != '0 && exMemRd == idExRs)
      mem_wins_a_chk: assert (fwdA == 2'b10) else $error("fwdA not 10");
    // R3
    if (exMemRegWrite && exMemRd != '0 && exMemRd == idExRt)
      mem_wins_b_chk: assert (fwdB == 2'b10) else $error("fwdB not 10");
    // R6 R7
    if (!(exMemRegWrite && exMemRd != '0) && !(memWbRegWrite && memWbRd != '0))
      no_live_chk: assert (fwdA == 2'b00 && fwdB == 2'b00) else $error("forward with no producer");
    // R9
    sel_legal_chk: assert (fwdA != 2'b11 && fwdB != 2'b11) else $error("illegal select");
    // R9
    bubble_pair_chk: assert (stall == bubble) else $error("stall and bubble differ");
    // R8
    if (!idExMemRead)
      no_load_chk: assert (!stall) else $error("stall without load");
  end

endmodule

bind hazard_unit hazard_unit_chk #(.IDX_W(IDX_W)) u_chk (
  .idExRs(idExRs), .idExRt(idExRt), .idExMemRead(idExMemRead),
  .exMemRd(exMemRd), .exMemRegWrite(exMemRegWrite),
  .memWbRd(memWbRd), .memWbRegWrite(memWbRegWrite),
  .fwdA(fwdA), .fwdB(fwdB), .stall(stall), .bubble(bubble)
);

// File: tb/sim_hazard_unit.sv
`timescale 1ns/1ps
module sim_hazard_unit;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic [4:0] idExRs, idExRt, exMemRd, memWbRd, ifIdRs, ifIdRt;
  logic idExMemRead, exMemRegWrite, memWbRegWrite;
  logic [1:0] fwdA, fwdB;
  logic stall, bubble;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  hazard_unit u0 (
    .idExRs(idExRs), .idExRt(idExRt), .idExMemRead(idExMemRead),
    .exMemRd(exMemRd), .exMemRegWrite(exMemRegWrite),
    .memWbRd(memWbRd), .memWbRegWrite(memWbRegWrite),
    .ifIdRs(ifIdRs), .ifIdRt(ifIdRt),
    .fwdA(fwdA), .fwdB(fwdB), .stall(stall), .bubble(bubble)
  );

  function automatic logic [1:0] expSel(input logic [4:0] src);
    if (exMemRegWrite && exMemRd != 0 && exMemRd == src) return 2'b10;
    if (memWbRegWrite && memWbRd != 0 && memWbRd == src) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic expStall();
    return idExMemRead && (idExRt == ifIdRs || idExRt == ifIdRt);
  endfunction

  task automatic chk(input string tag, input string what, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] rs, rt, input logic mr,
                       input logic [4:0] emRd, input logic emW,
                       input logic [4:0] mwRd, input logic mwW,
                       input logic [4:0] dRs, dRt);
    @(posedge clk);
    #0.5;
    idExRs = rs; idExRt = rt; idExMemRead = mr;
    exMemRd = emRd; exMemRegWrite = emW;
    memWbRd = mwRd; memWbRegWrite = mwW;
    ifIdRs = dRs; ifIdRt = dRt;
    @(negedge clk);
  endtask

  task automatic checkAll(input string tag);
    chk(tag, "fwdA", fwdA, expSel(idExRs));
    chk(tag, "fwdB", fwdB, expSel(idExRt));
    chk(tag, "stall", {1'b0, stall}, {1'b0, expStall()});
    chk("R9", "bubble", {1'b0, bubble}, {1'b0, expStall()});
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    idExRs = 0; idExRt = 0; idExMemRead = 0; exMemRd = 0; exMemRegWrite = 0;
    memWbRd = 0; memWbRegWrite = 0; ifIdRs = 0; ifIdRt = 0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 idle state
    chk("R1", "fwdA idle", fwdA, 2'b00);
    chk("R1", "fwdB idle", fwdB, 2'b00);
    chk("R8", "stall idle", {1'b0, stall}, 2'b00);

    // R1 distinct indices
    drive(5'd1, 5'd2, 0, 5'd3, 1, 5'd4, 1, 5'd5, 5'd6);
    chk("R1", "fwdA nomatch", fwdA, 2'b00);
    chk("R1", "fwdB nomatch", fwdB, 2'b00);
    // R2
    drive(5'd7, 5'd2, 0, 5'd7, 1, 5'd4, 1, 5'd0, 5'd0);
    chk("R2", "fwdA mem", fwdA, 2'b10);
    // R3
    drive(5'd1, 5'd9, 0, 5'd9, 1, 5'd4, 1, 5'd0, 5'd0);
    chk("R3", "fwdB mem", fwdB, 2'b10);
    // R4
    drive(5'd11, 5'd11, 0, 5'd3, 1, 5'd11, 1, 5'd0, 5'd0);
    chk("R4", "fwdA wb", fwdA, 2'b01);
    chk("R4", "fwdB wb", fwdB, 2'b01);
    // R5 both stages match
    drive(5'd12, 5'd12, 0, 5'd12, 1, 5'd12, 1, 5'd0, 5'd0);
    chk("R5", "fwdA prio", fwdA, 2'b10);
    chk("R5", "fwdB prio", fwdB, 2'b10);
    // R6 memory stage not writing: writeback wins
    drive(5'd13, 5'd2, 0, 5'd13, 0, 5'd13, 1, 5'd0, 5'd0);
    chk("R6", "fwdA mem off", fwdA, 2'b01);
    drive(5'd13, 5'd2, 0, 5'd3, 0, 5'd13, 0, 5'd0, 5'd0);
    chk("R6", "fwdA all off", fwdA, 2'b00);
    // R7 register 0
    drive(5'd0, 5'd0, 0, 5'd0, 1, 5'd0, 1, 5'd1, 5'd1);
    chk("R7", "fwdA r0", fwdA, 2'b00);
    chk("R7", "fwdB r0", fwdB, 2'b00);
    // R8 load-use on each decode source
    drive(5'd1, 5'd8, 1, 5'd0, 0, 5'd0, 0, 5'd8, 5'd3);
    chk("R8", "stall rs", {1'b0, stall}, 2'b01);
    chk("R9", "bubble rs", {1'b0, bubble}, 2'b01);
    drive(5'd1, 5'd8, 1, 5'd0, 0, 5'd0, 0, 5'd3, 5'd8);
    chk("R8", "stall rt", {1'b0, stall}, 2'b01);
    drive(5'd1, 5'd8, 0, 5'd0, 0, 5'd0, 0, 5'd8, 5'd8);
    chk("R8", "stall no load", {1'b0, stall}, 2'b00);
    drive(5'd1, 5'd8, 1, 5'd0, 0, 5'd0, 0, 5'd3, 5'd4);
    chk("R8", "stall no match", {1'b0, stall}, 2'b00);

    // random mix over small index range
    for (int i = 0; i < 2000; i++) begin
      drive(5'($urandom % 4), 5'($urandom % 4), 1'($urandom),
            5'($urandom % 4), 1'($urandom),
            5'($urandom % 4), 1'($urandom),
            5'($urandom % 4), 5'($urandom % 4));
      checkAll("R2 R3 R4 R5 R6 R7 R8 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule